// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic-logic unit. It is built from identical one-bit slices chained by their carries. A 3-bit operation code selects one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Every function works on two `WIDTH`-bit operands, with a default `WIDTH` of 32.

Each slice holds a full adder and a four-input result selector. The selector picks between the AND, the OR, the adder sum and a "less" input. One negate line inverts the second operand in every slice and also forces a carry of one into the lowest slice. That single line turns the adder chain into a subtractor.

For set-on-less-than, the unit subtracts. The top slice's raw sum bit is then fed back to the "less" input of slice 0. All other "less" inputs are zero.

Two flags come with the result:
- a zero flag, used for equality tests through subtraction;
- a signed-overflow flag, taken from the carries around the top slice.

The block has no clock and no state. The bench paces its stimulus with a clock of its own. The block therefore has no states or transitions to name.

Top module: `ripple_alu`

## Requirements
- R1: Operation code 3'b000 gives `res` = `opa` AND `opb`, bit by bit.
- R2: Operation code 3'b001 gives `res` = `opa` OR `opb`, bit by bit.
- R3: Operation code 3'b010 gives `res` = (`opa` + `opb`) mod 2^WIDTH.
- R4: Operation code 3'b110 gives `res` = (`opa` - `opb`) mod 2^WIDTH.
- R5: Operation code 3'b111 gives `res` bit 0 equal to the most significant bit of (`opa` - `opb`) mod 2^WIDTH. All other bits of `res` are 0. When the subtraction does not overflow, bit 0 is 1 exactly when `opa` < `opb` as signed numbers.
- R6: Set-on-less-than applies no overflow correction. With `opa` = 32'h7FFFFFFF and `opb` = 32'hFFFFFFFF, `res` = 1.
- R7: `zero` is 1 exactly when every bit of `res` is 0.
- R8: For code 3'b010, `ovf` is 1 exactly when the operands share a sign bit and the sum's sign bit differs from it.
- R9: For code 3'b110, `ovf` is 1 exactly when the operands' sign bits differ and the difference's sign bit equals `opb`'s sign bit.
- R10: For codes 3'b000, 3'b001 and 3'b111, `ovf` is 0.
- R11: Codes 3'b011, 3'b100 and 3'b101 give `res` = 0 and `ovf` = 0, and hence `zero` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op | input | 3 | Operation code |
| res | output | WIDTH | Result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of an add or subtract |

## Verification
The bench targets the sign-boundary operands: 0, 1, all ones, the most positive value and the most negative value.

- A wrong carry-in on subtraction would give results off by one.
- An overflow flag taken from the carry-out alone would fire for unsigned wraps, such as all ones plus one.
- A set-on-less-than that corrects for overflow, or that reads a bit other than the top sum, would miss the 32'h7FFFFFFF versus -1 case.

The unused operation codes are driven with nonzero operands. A design that let them fall through to a slice function would show a nonzero result or a raised overflow.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0]  op,
    output logic        negate,
    output slice_sel_e  sel,
    output logic        arith,
    output logic        valid
);
    always_comb begin
        negate = 1'b0;
        sel    = SEL_AND;
        arith  = 1'b0;
        valid  = 1'b1;
        unique case (op)
            OP_AND: sel = SEL_AND;
            OP_OR:  sel = SEL_OR;
            OP_ADD: begin
                sel   = SEL_SUM;
                arith = 1'b1;
            end
            OP_SUB: begin
                sel    = SEL_SUM;
                negate = 1'b1;
                arith  = 1'b1;
            end
            OP_SLT: begin
                sel    = SEL_LESS;
                negate = 1'b1;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic        a,
    input  logic        b,
    input  logic        cin,
    input  logic        less,
    input  logic        negate,
    input  slice_sel_e  sel,
    output logic        res,
    output logic        sum,
    output logic        cout
);
    logic bx;

    always_comb begin
        bx   = b ^ negate;
        sum  = a ^ bx ^ cin;
        cout = (a & bx) | (a & cin) | (bx & cin);
        unique case (sel)
            SEL_AND:  res = a & bx;
            SEL_OR:   res = a | bx;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] res,
    output logic             zero,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic       negate;
    logic       arith;
    logic       valid;
    slice_sel_e sel;
    logic [WIDTH-1:0] raw;
    logic       set_bit;
    logic       ovf_raw;

    alu_decode u_dec (
        .op     (op),
        .negate (negate),
        .sel    (sel),
        .arith  (arith),
        .valid  (valid)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic ci;
        logic co;
        logic sm;
        logic lv;
        if (i == 0) begin : g_lsb
            assign ci = negate;
            assign lv = set_bit;
        end else begin : g_upper
            assign ci = g_slice[i-1].co;
            assign lv = 1'b0;
        end
        alu_slice u_slice (
            .a      (opa[i]),
            .b      (opb[i]),
            .cin    (ci),
            .less   (lv),
            .negate (negate),
            .sel    (sel),
            .res    (raw[i]),
            .sum    (sm),
            .cout   (co)
        );
    end

    assign set_bit = g_slice[MSB].sm;
    assign ovf_raw = g_slice[MSB].ci ^ g_slice[MSB].co;

    always_comb begin
        res  = valid ? raw : '0;
        ovf  = valid & arith & ovf_raw;
        zero = ~|res;
    end

    always_comb begin
        // R3
        add_sum_chk: assert (!(op == OP_ADD) || res == opa + opb);
        // R4
        sub_diff_chk: assert (!(op == OP_SUB) || res == opa - opb);
        // R5
        slt_upper_chk: assert (!(op == OP_SLT) || res[WIDTH-1:1] == '0);
        // R8
        add_ovf_chk: assert (!(op == OP_ADD) ||
            ovf == ((opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB])));
        // R10
        no_overflow_chk: assert (!(op == OP_AND || op == OP_OR || op == OP_SLT) || !ovf);
        // R11
        bad_op_chk: assert (!(op == 3'b011 || op == 3'b100 || op == 3'b101) ||
            (res == '0 && !ovf && zero));
    end
endmodule

// File: tb/tb_ripple_alu.sv
module tb_ripple_alu;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] opa, opb, res;
    logic [2:0]   op;
    logic         zero, ovf;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ripple_alu #(.WIDTH(W)) dut (
        .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
    );

    function automatic logic [W-1:0] exp_res(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] d;
        d = a - b;
        case (c)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return d;
            3'b111:  return {{(W-1){1'b0}}, d[W-1]};
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_ovf(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] s;
        if (c == 3'b010) begin
            s = a + b;
            return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
        end
        if (c == 3'b110) begin
            s = a - b;
            return (a[W-1] != b[W-1]) && (s[W-1] == b[W-1]);
        end
        return 1'b0;
    endfunction

    function automatic string tag(logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3/R8";
            3'b110:  return "R4/R9";
            3'b111:  return "R5/R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (op=%b a=%h b=%h)", r, act, exp, op, opa, opb);
        end
    endtask

    task automatic apply(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] er;
        @(negedge clk);
        op = c; opa = a; opb = b;
        #1;
        er = exp_res(c, a, b);
        chk(tag(c), res, er);
        chk({"R7 ", tag(c)}, {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
        chk({"ovf ", tag(c)}, {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf(c, a, b)});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corner [5];
        int unused;
        corner[0] = 32'h0000_0000;
        corner[1] = 32'h0000_0001;
        corner[2] = 32'h7FFF_FFFF;
        corner[3] = 32'h8000_0000;
        corner[4] = 32'hFFFF_FFFF;
        unused = $urandom(32'd20240611);
        op = 3'b000; opa = '0; opb = '0;
        #1;
        // reset-free start: AND of zeros gives zero result and zero flag (R1, R7)
        chk("R1 initial", res, '0);
        chk("R7 initial", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        // R6: overflowed compare reports raw sign
        apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        chk("R6", res, 32'h1);
        // R5: plain signed compares
        apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);
        chk("R5 -1<1", res, 32'h1);
        apply(3'b111, 32'h0000_0005, 32'h0000_0005);
        chk("R5 equal", res, 32'h0);
        // R7: equality through subtraction
        apply(3'b110, 32'h1234_5678, 32'h1234_5678);
        // R8: unsigned wrap is not signed overflow
        apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
        // R9
        apply(3'b110, 32'h8000_0000, 32'h0000_0001);
        // R11 with nonzero operands
        apply(3'b011, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
        apply(3'b100, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        apply(3'b101, 32'h8000_0000, 32'h8000_0000);
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    apply(3'(c), corner[i], corner[j]);
        for (int n = 0; n < 2000; n++) begin
            logic [W-1:0] a, b;
            a = $urandom();
            b = $urandom();
            if (n % 7 == 0) b = a;
            if (n % 11 == 0) a = corner[n % 5];
            apply(3'($urandom_range(7, 0)), a, b);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule